// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits behind a serial memory front end that has already turned the wire traffic into decoded commands and whole data bytes. During a write transaction it gathers data bytes into a 128-byte page buffer. The page is fixed by the upper bits of the start address. A 7-bit in-page offset advances after every byte and wraps inside the page. When the transaction ends cleanly, the buffered page is merged into a backing byte array during a self-timed program cycle. Bytes that were never sent keep their earlier value. Any byte may be rewritten directly, so no erase step is needed.

The block holds the write-enable latch and reports a busy flag for the whole program cycle. The latch clears by itself once the program cycle finishes. Read transactions stream bytes from an address pointer that covers the whole array and wraps from the top address back to zero. The protection decision is made outside this block and arrives as a single allow level, which is sampled when the transaction ends. The program cycle length is set in system clocks by a parameter.

Top module: `pwb_ctrl`

## Requirements
- R1: A write command latches page index `cmd_addr[ADDR_W-1:7]` and offset `cmd_addr[6:0]`. Each accepted data byte is stored at the current offset, and then only the 7-bit offset increments. The page index stays fixed for the whole transaction.
- R2: If more than 128 bytes are sent, the offset wraps from 127 to 0. The later bytes replace the earlier buffered bytes at the same offsets.
- R3: When a page is committed, only the offsets written in that transaction change in the array. Every other byte of the page keeps its old value. A written byte takes its new value no matter what was stored there before.
- R4: A commit starts only on deselect, which is `sel` falling (seen on the first clock with `sel` low), and only when all three of these hold on that clock: a write is armed, at least one byte was received, and `frag_pending` is low. Otherwise the buffered data is discarded and `busy` stays low.
- R5: If `wr_allow` is low on the deselect clock, the write is discarded, no program cycle starts, and `wel` keeps its value.
- R6: `busy` rises on the clock after the deselect clock and stays high for exactly `PROG_CYCLES` clocks. The array takes the new page in the clock where `busy` falls.
- R7: `cmd_op` encodings are: 0 none, 1 read, 2 write, 3 set write-enable, 4 clear write-enable. Commands count only while `sel` is high. A write command given while `wel` is low is ignored, and nothing is committed for it.
- R8: `wel` clears in the same clock that `busy` falls.
- R9: After a read command at address A, each `rd_req` pulse gives `rd_valid` high one clock later, with `rd_data` equal to the byte at the current pointer. The pointer starts at A, increments after every byte, and wraps from 2^ADDR_W-1 to 0.
- R10: While `busy` is high, every command (read, write, set or clear write-enable) is ignored, and `rd_req` produces no data.
- R11: After reset, `busy`, `wel` and `rd_valid` are low and every array byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | High while the device is selected (transaction in progress) |
| frag_pending | input | 1 | High when a byte is only partly shifted in |
| cmd_op | input | 3 | Decoded command, one-cycle pulse (encoding in R7) |
| cmd_addr | input | ADDR_W | Start address of a read or write command |
| byte_valid | input | 1 | One-cycle strobe for a received data byte |
| byte_data | input | 8 | Received data byte |
| wr_allow | input | 1 | Protection decision for the open page, sampled at deselect |
| rd_req | input | 1 | Request for the next read byte |
| rd_valid | output | 1 | Read byte present on `rd_data` |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Program cycle in progress |
| wel | output | 1 | Write-enable latch |

## Verification
The page path is tried with four write patterns, each targeting a different failure:
- A short burst in mid-page shows whether untouched neighbours survive the merge.
- A burst that starts at offset 126 shows that the offset wraps inside the page rather than carrying into the page index.
- A 130-byte burst shows that late bytes overwrite the first ones.
- A rewrite of a populated byte shows that no erase is assumed.

Writes that must be discarded are also driven: with the latch clear, with a partial byte at deselect, with no data bytes, and with the allow input low. These show that each gating term blocks a program cycle on its own. Reads from the top address show the full-array wrap. Commands issued while busy show that they leave the latch and the read path untouched.

// File: rtl/pwb_pkg.sv
// Package: shared command encoding and byte width for the page write buffer.
package pwb_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_READ    = 3'd1,
        OP_WRITE   = 3'd2,
        OP_WEL_SET = 3'd3,
        OP_WEL_CLR = 3'd4
    } op_e;
endpackage

// File: rtl/pwb_page_buf.sv
// Page staging buffer: one byte slot and one written flag per page offset.
// Assumes open and wr_en are never high in the same cycle; open wins if they are.
module pwb_page_buf #(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned PAGE_BITS = 7,
    localparam int unsigned PAGE_BYTES = 1 << PAGE_BITS,
    localparam int unsigned PIDX_W     = ADDR_W - PAGE_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        open,
    input  logic [ADDR_W-1:0]           open_addr,
    input  logic                        wr_en,
    input  logic [pwb_pkg::BYTE_W-1:0]  wr_data,
    output logic [PIDX_W-1:0]           page_idx,
    output logic [PAGE_BYTES*pwb_pkg::BYTE_W-1:0] page_data,
    output logic [PAGE_BYTES-1:0]       page_mask
);
    logic [PAGE_BITS-1:0] off_q;
    logic [PIDX_W-1:0]    page_q;

    // Page index is latched once per write; offset advances and wraps within the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            page_q <= '0;
        end else if (open) begin
            off_q  <= open_addr[PAGE_BITS-1:0];
            page_q <= open_addr[ADDR_W-1:PAGE_BITS];
        end else if (wr_en) begin
            off_q  <= off_q + 1'b1;
        end
    end

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        logic [pwb_pkg::BYTE_W-1:0] slot_q;
        logic                       hit_q;

        // Slot s captures a byte when the offset points at it; open clears its flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
                hit_q  <= 1'b0;
            end else if (open) begin
                hit_q  <= 1'b0;
            end else if (wr_en && (off_q == PAGE_BITS'(s))) begin
                slot_q <= wr_data;
                hit_q  <= 1'b1;
            end
        end

        assign page_data[s*pwb_pkg::BYTE_W +: pwb_pkg::BYTE_W] = slot_q;
        assign page_mask[s] = hit_q;
    end

    assign page_idx = page_q;
endmodule

// File: rtl/pwb_prog_timer.sv
// Self-timed program cycle: busy for PROG_CYCLES clocks after start.
// done pulses in the last busy clock. Assumes PROG_CYCLES >= 1.
module pwb_prog_timer #(
    parameter int unsigned PROG_CYCLES = 500000,
    localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    // Load the remaining count on start, then count down to zero and drop busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(PROG_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/pwb_array.sv
// Backing byte array: masked whole-page write port and an asynchronous byte read.
// Reset clears every byte; a page write touches only the flagged offsets.
module pwb_array #(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned PAGE_BITS = 7,
    localparam int unsigned DEPTH      = 1 << ADDR_W,
    localparam int unsigned PAGE_BYTES = 1 << PAGE_BITS,
    localparam int unsigned PIDX_W     = ADDR_W - PAGE_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pg_we,
    input  logic [PIDX_W-1:0]           pg_idx,
    input  logic [PAGE_BYTES*pwb_pkg::BYTE_W-1:0] pg_data,
    input  logic [PAGE_BYTES-1:0]       pg_mask,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [pwb_pkg::BYTE_W-1:0]  rd_q
);
    logic [pwb_pkg::BYTE_W-1:0] mem [DEPTH];

    // Merge the flagged bytes of the staged page into storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else if (pg_we) begin
            for (int s = 0; s < PAGE_BYTES; s++) begin
                if (pg_mask[s]) mem[{pg_idx, PAGE_BITS'(s)}] <= pg_data[s*pwb_pkg::BYTE_W +: pwb_pkg::BYTE_W];
            end
        end
    end

    assign rd_q = mem[rd_addr];
endmodule

// File: rtl/pwb_ctrl.sv
// Page write buffer controller (top). Takes decoded commands and whole bytes.
// Stages one page and commits it on a clean deselect when the latch and the
// protection input allow it. Serves wrapping sequential reads.
// Assumes commands, bytes and read requests are never on the same clock.
module pwb_ctrl
    import pwb_pkg::*;
#(
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned PAGE_BITS   = 7,
    parameter int unsigned PROG_CYCLES = 500000,
    localparam int unsigned PAGE_BYTES = 1 << PAGE_BITS,
    localparam int unsigned PIDX_W     = ADDR_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              frag_pending,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              wr_allow,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              busy,
    output logic              wel
);
    op_e                       op_w;
    logic                      sel_q, wr_armed_q, rd_armed_q, wel_q;
    logic                      rd_valid_q;
    logic [BYTE_W-1:0]         rd_data_q;
    logic [ADDR_W-1:0]         rd_ptr_q;
    logic                      accept, wr_open, rd_open, desel, buf_wr, commit;
    logic                      prog_busy, prog_done;
    logic [PIDX_W-1:0]         pg_idx;
    logic [PAGE_BYTES*BYTE_W-1:0] pg_data;
    logic [PAGE_BYTES-1:0]     pg_mask;
    logic [BYTE_W-1:0]         arr_q;

    assign op_w    = op_e'(cmd_op);
    assign accept  = sel && !prog_busy;
    assign wr_open = accept && (op_w == OP_WRITE) && wel_q;
    assign rd_open = accept && (op_w == OP_READ);
    assign desel   = sel_q && !sel;
    assign buf_wr  = sel && wr_armed_q && byte_valid;
    assign commit  = desel && wr_armed_q && (|pg_mask) && !frag_pending && wr_allow;

    pwb_page_buf #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .open      (wr_open),
        .open_addr (cmd_addr),
        .wr_en     (buf_wr),
        .wr_data   (byte_data),
        .page_idx  (pg_idx),
        .page_data (pg_data),
        .page_mask (pg_mask)
    );

    pwb_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit),
        .busy  (prog_busy),
        .done  (prog_done)
    );

    pwb_array #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .pg_we   (prog_done),
        .pg_idx  (pg_idx),
        .pg_data (pg_data),
        .pg_mask (pg_mask),
        .rd_addr (rd_ptr_q),
        .rd_q    (arr_q)
    );

    // Track select to find the deselect clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel;
    end

    // Write arming: set by an enabled write command, dropped at deselect.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_armed_q <= 1'b0;
        else if (desel)   wr_armed_q <= 1'b0;
        else if (wr_open) wr_armed_q <= 1'b1;
    end

    // Write-enable latch: commands while idle, self-clear at end of program.
    always_ff @(posedge clk) begin
        if (!rst_n)                              wel_q <= 1'b0;
        else if (prog_done)                      wel_q <= 1'b0;
        else if (accept && op_w == OP_WEL_SET)   wel_q <= 1'b1;
        else if (accept && op_w == OP_WEL_CLR)   wel_q <= 1'b0;
    end

    // Read arming and full-array wrapping pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_armed_q <= 1'b0;
            rd_ptr_q   <= '0;
        end else if (desel) begin
            rd_armed_q <= 1'b0;
        end else if (rd_open) begin
            rd_armed_q <= 1'b1;
            rd_ptr_q   <= cmd_addr;
        end else if (sel && rd_armed_q && rd_req) begin
            rd_ptr_q   <= rd_ptr_q + 1'b1;
        end
    end

    // Registered read byte, one clock after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= sel && rd_armed_q && rd_req;
            if (sel && rd_armed_q && rd_req) rd_data_q <= arr_q;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
    assign busy     = prog_busy;
    assign wel      = wel_q;
endmodule

// File: rtl/pwb_ctrl_chk.sv
// Checker for pwb_ctrl: program cycle length, start conditions, latch and read rules.
module pwb_ctrl_chk #(
    parameter int unsigned PROG_CYCLES = 500000,
    localparam int unsigned LEN_W = $clog2(PROG_CYCLES + 1) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic sel,
    input logic frag_pending,
    input logic wr_allow,
    input logic rd_req,
    input logic rd_valid,
    input logic busy,
    input logic wel
);
    logic [LEN_W-1:0] blen_q;

    // Count busy clocks already elapsed in the current program cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    blen_q <= '0;
        else if (busy) blen_q <= blen_q + 1'b1;
        else           blen_q <= '0;
    end

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (blen_q < LEN_W'(PROG_CYCLES)));

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(blen_q) == LEN_W'(PROG_CYCLES - 1)));

    // R4 R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!$past(sel) && !$past(frag_pending) && $past(wr_allow)));

    // R8
    wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R10
    wel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !$past(busy));

    // R9 R10
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_req) && !$past(busy)));
endmodule

bind pwb_ctrl pwb_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel          (sel),
    .frag_pending (frag_pending),
    .wr_allow     (wr_allow),
    .rd_req       (rd_req),
    .rd_valid     (rd_valid),
    .busy         (busy),
    .wel          (wel)
);

// File: tb/tb_pwb_ctrl.sv
module tb_pwb_ctrl;
    localparam int AW = 10;
    localparam int PB = 7;
    localparam int PROG = 16;
    localparam int DEPTH = 1 << AW;
    localparam int PSZ = 1 << PB;

    logic clk = 0, rst_n = 0, sel = 0, frag_pending = 0, byte_valid = 0, wr_allow = 1, rd_req = 0;
    logic [2:0] cmd_op = 0;
    logic [AW-1:0] cmd_addr = 0;
    logic [7:0] byte_data = 0;
    logic rd_valid, busy, wel;
    logic [7:0] rd_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] got [8];

    pwb_ctrl #(.ADDR_W(AW), .PAGE_BITS(PB), .PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .frag_pending(frag_pending),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .byte_valid(byte_valid),
        .byte_data(byte_data), .wr_allow(wr_allow), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .wel(wel));

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_mem [DEPTH];
    logic [7:0] m_buf [PSZ];
    bit m_hit [PSZ];
    bit m_busy, m_wel, m_rv, m_selq, m_warm, m_rarm;
    int m_cnt, m_page, m_off, m_rptr;
    logic [7:0] m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_wel = 0; m_rv = 0; m_selq = 0; m_warm = 0; m_rarm = 0;
            m_cnt = 0; m_rd = 0;
            for (int a = 0; a < DEPTH; a++) m_mem[a] = 0;
        end else begin
            bit fall, any;
            fall = m_selq && !sel;
            m_rv = 0;
            if (m_busy) begin
                if (m_cnt == 0) begin
                    m_busy = 0; m_wel = 0;
                    for (int k = 0; k < PSZ; k++) if (m_hit[k]) m_mem[m_page * PSZ + k] = m_buf[k];
                end else m_cnt--;
            end else if (sel) begin
                case (cmd_op)
                    3'd1: begin m_rarm = 1; m_rptr = int'(cmd_addr); end
                    3'd2: if (m_wel) begin
                              m_warm = 1; m_page = int'(cmd_addr) / PSZ; m_off = int'(cmd_addr) % PSZ;
                              for (int k = 0; k < PSZ; k++) m_hit[k] = 0;
                          end
                    3'd3: m_wel = 1;
                    3'd4: m_wel = 0;
                    default: ;
                endcase
            end
            if (sel && m_warm && byte_valid) begin
                m_buf[m_off] = byte_data; m_hit[m_off] = 1; m_off = (m_off + 1) % PSZ;
            end
            if (sel && m_rarm && rd_req) begin
                m_rv = 1; m_rd = m_mem[m_rptr]; m_rptr = (m_rptr + 1) % DEPTH;
            end
            if (fall) begin
                any = 0;
                for (int k = 0; k < PSZ; k++) any |= m_hit[k];
                if (m_warm && any && !frag_pending && wr_allow) begin m_busy = 1; m_cnt = PROG - 1; end
                m_warm = 0; m_rarm = 0;
            end
            m_selq = sel;
        end
    end

    // Compare outputs with the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == m_busy, "R6 busy", int'(busy), int'(m_busy));
            chk(wel == m_wel, "R8 wel", int'(wel), int'(m_wel));
            chk(rd_valid == m_rv, "R9 rd_valid", int'(rd_valid), int'(m_rv));
            if (m_rv) chk(rd_data == m_rd, "R9 rd_data", int'(rd_data), int'(m_rd));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic begin_txn();
        @(negedge clk) sel = 1;
    endtask

    task automatic end_txn(input bit frag);
        @(negedge clk) begin sel = 0; frag_pending = frag; end
        @(negedge clk) frag_pending = 0;
    endtask

    task automatic cmd(input logic [2:0] op, input int a);
        @(negedge clk) begin cmd_op = op; cmd_addr = AW'(a); end
        @(negedge clk) cmd_op = 0;
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk) begin byte_valid = 1; byte_data = d; end
        @(negedge clk) byte_valid = 0;
    endtask

    task automatic set_wel();
        begin_txn(); cmd(3'd3, 0); end_txn(0);
    endtask

    task automatic wr_txn(input int a, input logic [7:0] d[$], input bit frag);
        begin_txn(); cmd(3'd2, a);
        foreach (d[i]) send(d[i]);
        end_txn(frag);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic read_seq(input int a, input int n);
        begin_txn(); cmd(3'd1, a);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) rd_req = 1;
            @(negedge clk) rd_req = 0;
            got[i] = rd_data;
        end
        end_txn(0);
    endtask

    task automatic report();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
    end

    initial begin
        logic [7:0] q[$];
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(busy == 0, "R11 busy", int'(busy), 0);
        chk(wel == 0, "R11 wel", int'(wel), 0);
        chk(rd_valid == 0, "R11 rd_valid", int'(rd_valid), 0);
        read_seq(300, 2);
        chk(got[0] == 0 && got[1] == 0, "R11 array zero", int'({got[0], got[1]}), 0);

        // R7 write ignored with the latch clear
        wr_txn(512, '{8'hEE}, 0);
        chk(busy == 0, "R7 no busy", int'(busy), 0);
        read_seq(512, 1);
        chk(got[0] == 8'h00, "R7 array untouched", int'(got[0]), 0);

        // R1 R3 R6 R8 mid-page burst
        set_wel();
        chk(wel == 1, "R7 wel set", int'(wel), 1);
        wr_txn(261, '{8'hA1, 8'hB2, 8'hC3}, 0);
        chk(busy == 1, "R6 busy start", int'(busy), 1);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk(n == PROG, "R6 busy length", n, PROG);
        chk(wel == 0, "R8 wel cleared", int'(wel), 0);
        read_seq(260, 5);
        chk(got[0] == 8'h00, "R3 left neighbour", int'(got[0]), 0);
        chk(got[1] == 8'hA1 && got[2] == 8'hB2 && got[3] == 8'hC3, "R1 burst", int'({got[1], got[2], got[3]}), 'hA1B2C3);
        chk(got[4] == 8'h00, "R3 right neighbour", int'(got[4]), 0);

        // R1 offset wraps inside page 3, not into page 4
        set_wel();
        wr_txn(510, '{8'h11, 8'h22, 8'h33, 8'h44}, 0);
        wait_idle();
        read_seq(510, 3);
        chk(got[0] == 8'h11 && got[1] == 8'h22 && got[2] == 8'h00, "R1 page end", int'({got[0], got[1], got[2]}), 'h112200);
        read_seq(384, 2);
        chk(got[0] == 8'h33 && got[1] == 8'h44, "R1 page wrap", int'({got[0], got[1]}), 'h3344);

        // R2 130-byte burst overwrites offsets 0 and 1
        set_wel();
        q = {};
        for (int i = 0; i < 130; i++) q.push_back(8'(i) ^ 8'h5A);
        wr_txn(128, q, 0);
        wait_idle();
        read_seq(128, 3);
        chk(got[0] == 8'hDA && got[1] == 8'hDB && got[2] == 8'h58, "R2 overflow", int'({got[0], got[1], got[2]}), 'hDADB58);

        // R3 rewrite without erase
        set_wel();
        wr_txn(261, '{8'h0F}, 0);
        wait_idle();
        read_seq(260, 3);
        chk(got[1] == 8'h0F && got[2] == 8'hB2, "R3 rewrite", int'({got[1], got[2]}), 'h0FB2);

        // R9 read wraps from the top address to zero
        set_wel(); wr_txn(1023, '{8'h77}, 0); wait_idle();
        set_wel(); wr_txn(0, '{8'h99}, 0); wait_idle();
        read_seq(1023, 2);
        chk(got[0] == 8'h77 && got[1] == 8'h99, "R9 top wrap", int'({got[0], got[1]}), 'h7799);

        // R4 partial byte at deselect, then no data bytes
        set_wel();
        wr_txn(640, '{8'h55}, 1);
        chk(busy == 0, "R4 partial byte", int'(busy), 0);
        chk(wel == 1, "R4 wel kept", int'(wel), 1);
        wr_txn(700, '{}, 0);
        chk(busy == 0, "R4 no bytes", int'(busy), 0);
        read_seq(640, 1);
        chk(got[0] == 8'h00, "R4 discarded", int'(got[0]), 0);

        // R5 protection denies the commit
        wr_allow = 0;
        wr_txn(768, '{8'h66}, 0);
        chk(busy == 0, "R5 no busy", int'(busy), 0);
        chk(wel == 1, "R5 wel kept", int'(wel), 1);
        wr_allow = 1;
        read_seq(768, 1);
        chk(got[0] == 8'h00, "R5 discarded", int'(got[0]), 0);

        // R10 commands ignored while busy
        wr_txn(800, '{8'h42}, 0);
        begin_txn();
        cmd(3'd4, 0);
        chk(wel == 1 && busy == 1, "R10 clear ignored", int'({wel, busy}), 3);
        cmd(3'd1, 260);
        @(negedge clk) rd_req = 1;
        @(negedge clk) rd_req = 0;
        chk(rd_valid == 0, "R10 read ignored", int'(rd_valid), 0);
        cmd(3'd2, 801);
        send(8'h43);
        end_txn(0);
        wait_idle();
        chk(wel == 0, "R8 wel after cycle", int'(wel), 0);
        read_seq(800, 2);
        chk(got[0] == 8'h42 && got[1] == 8'h00, "R10 write ignored", int'({got[0], got[1]}), 'h4200);

        report();
    end
endmodule